// File: doc/BRIEF.md
# Multi-Port Result Drain to Local Memory

This block sits on the output side of an accelerator wrapper. A computing core exposes several result ports. Each port streams tokens with a valid/ready handshake into a FIFO of its own, so producing results never waits on memory access. A round-robin selector picks one FIFO that holds data and whose port still expects results. The controller then empties that FIFO into the single write port of a local dual-port memory, one word per cycle. The write address of each word is the port's configured base address plus the number of words already stored for that port.

There is no start command. Storing begins as soon as results appear. Each port has a configured total. When every port's stored count has reached its total, the block emits a single-cycle finish pulse. A clear command from the input-loading side zeroes the counters and arms the finish pulse again for the next transaction. Base addresses and totals come from a shared register bank as plain inputs.

Top module: `result_storer`

## Requirements
- R1: After reset, every `res_ready` bit is 1, and `res_ack`, `mem_we` and `finish` are 0. The selector priority starts at port 0, and all counters are 0.
- R2: A token is accepted when `res_valid[p]` and `res_ready[p]` are both 1 at a clock edge. Each accepted token produces exactly one single-cycle pulse on `res_ack[p]` in the following cycle.
- R3: `res_ready[p]` is 0 exactly while the FIFO of port p holds FIFO_DEPTH tokens. A token presented to a full FIFO is neither taken nor lost: it is accepted once space frees up.
- R4: Every word stored for port p is written to address `cfg_base[p] + n`, where n is the number of words already stored for that port since the last clear or reset. Words of a port are stored in the order they were accepted.
- R5: Once a port is selected, it keeps being served until its FIFO is empty or its count is complete. Only then can another port be selected.
- R6: Selection is round-robin. After port p has been served, the search for the next port starts at port p+1, wrapping after the last port. Only ports whose FIFO is non-empty and whose count is below its total are candidates.
- R7: `finish` is a one-cycle pulse, raised in the cycle after every port's count has reached its total. At that point all expected words have been written. It is not raised again until a clear.
- R8: `clr` zeroes all counters and re-arms `finish`. If all totals are 0, `finish` pulses once, two cycles after the clear edge.
- R9: A port whose count has reached its total gets no further writes. Extra tokens stay in its FIFO, and its ready flag still reflects the FIFO occupancy.
- R10: At most one word is written per cycle. While the selected FIFO stays non-empty, its words are written on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Clear command: zeroes counters, re-arms finish |
| cfg_base | input | NPORTS*AW | Per-port base address, port p at bits [p*AW +: AW] |
| cfg_total | input | NPORTS*CW | Per-port word total, port p at bits [p*CW +: CW] |
| res_data | input | NPORTS*DW | Per-port result data, port p at bits [p*DW +: DW] |
| res_valid | input | NPORTS | Per-port result valid |
| res_ready | output | NPORTS | Per-port FIFO not full |
| res_ack | output | NPORTS | Per-port pulse acknowledging an accepted token |
| mem_we | output | 1 | Local memory write enable |
| mem_addr | output | AW | Local memory write address |
| mem_wdata | output | DW | Local memory write data |
| finish | output | 1 | One-cycle pulse when all port totals are stored |

## Verification
The bench builds the block with three ports, 16-bit data, 8-bit addresses, 6-bit counts and a FIFO depth of 4. The shallow FIFO lets a continuous stream fill a waiting port and drive its ready flag low within a few cycles. With three ports, the wrap of the round-robin order can be observed. Every combination of totals 0 to 3 across the three ports is swept, including the all-zero case that finishes straight after a clear. Each data word encodes its round, port and index, so the expected address and order of every write follow arithmetically. Two further runs cover a long stream on all ports at once, which exercises draining, switching and full FIFOs, and a port that receives more tokens than its total.

// File: rtl/storer_pkg.sv
package storer_pkg;

  typedef enum logic {
    ST_PICK  = 1'b0,
    ST_DRAIN = 1'b1
  } drain_state_t;

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/storer_fifo.sv
// Per-port result FIFO with first-word-fall-through head.
module storer_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          in_ack,
  input  logic          out_pop,
  output logic [DW-1:0] out_head,
  output logic          out_nonempty
);
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [DW-1:0]   store [DEPTH];
  logic [PW-1:0]   wr_ptr, rd_ptr;
  logic [CNTW-1:0] count;
  logic            push;

  assign in_ready     = (count != CNTW'(DEPTH));
  assign push         = in_valid && in_ready;
  assign out_nonempty = (count != '0);
  assign out_head     = store[rd_ptr];

  // storage array without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      in_ack <= 1'b0;
    end else begin
      in_ack <= push;
      if (push)
        wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
      if (out_pop)
        rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
      case ({push, out_pop})
        2'b10:   count <= count + CNTW'(1);
        2'b01:   count <= count - CNTW'(1);
        default: count <= count;
      endcase
    end
  end

  // R3: occupancy never exceeds the configured depth
  a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CNTW'(DEPTH));

  // R10: controller only pops a FIFO that holds data
  a_r10_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
    out_pop |-> count != '0);

endmodule

// File: rtl/storer_rr.sv
// Round-robin pick: first requesting index at or after ptr, wrapping.
module storer_rr #(
  parameter int NP = 4,
  parameter int IW = 2
) (
  input  logic [NP-1:0] req,
  input  logic [IW-1:0] ptr,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    // walk from farthest offset down so the nearest request wins
    for (int i = NP - 1; i >= 0; i--) begin
      if (req[(int'(ptr) + i) % NP]) begin
        any = 1'b1;
        idx = IW'((int'(ptr) + i) % NP);
      end
    end
  end
endmodule

// File: rtl/storer_ctrl.sv
// Drain controller: selection, per-port counters, address, finish.
module storer_ctrl
  import storer_pkg::*;
#(
  parameter int NP = 4,
  parameter int DW = 32,
  parameter int AW = 10,
  parameter int CW = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [NP-1:0]    nonempty,
  input  logic [NP*DW-1:0] head,
  input  logic [NP*AW-1:0] base,
  input  logic [NP*CW-1:0] total,
  output logic [NP-1:0]    pop,
  output logic             we,
  output logic [AW-1:0]    addr,
  output logic [DW-1:0]    wdata,
  output logic             finish
);
  localparam int IW = idx_bits(NP);

  drain_state_t  state;
  logic [IW-1:0] sel, rr_ptr, g_idx;
  logic          g_any;
  logic [CW-1:0] cnt [NP];
  logic [NP-1:0] done, elig;
  logic          all_done, fin_sent, serve;
  logic [DW-1:0] head_sel;
  logic [AW-1:0] base_sel;
  logic [CW-1:0] cnt_sel;

  always_comb begin
    for (int p = 0; p < NP; p++)
      done[p] = (cnt[p] >= total[p*CW +: CW]);
  end

  assign elig     = nonempty & ~done;
  assign all_done = &done;
  assign head_sel = head[sel*DW +: DW];
  assign base_sel = base[sel*AW +: AW];
  assign cnt_sel  = cnt[sel];
  assign serve    = (state == ST_DRAIN) && !clr && elig[sel];

  always_comb begin
    for (int p = 0; p < NP; p++)
      pop[p] = serve && (sel == IW'(p));
  end

  storer_rr #(.NP(NP), .IW(IW)) u_rr (
    .req (elig),
    .ptr (rr_ptr),
    .any (g_any),
    .idx (g_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_PICK;
      sel      <= '0;
      rr_ptr   <= '0;
      we       <= 1'b0;
      addr     <= '0;
      wdata    <= '0;
      finish   <= 1'b0;
      fin_sent <= 1'b0;
      for (int p = 0; p < NP; p++) cnt[p] <= '0;
    end else if (clr) begin
      state    <= ST_PICK;
      we       <= 1'b0;
      finish   <= 1'b0;
      fin_sent <= 1'b0;
      for (int p = 0; p < NP; p++) cnt[p] <= '0;
    end else begin
      we       <= 1'b0;
      finish   <= all_done && !fin_sent;
      fin_sent <= fin_sent || all_done;
      case (state)
        ST_PICK: begin
          if (g_any) begin
            sel    <= g_idx;
            rr_ptr <= (g_idx == IW'(NP - 1)) ? '0 : g_idx + IW'(1);
            state  <= ST_DRAIN;
          end
        end
        default: begin
          if (elig[sel]) begin
            we       <= 1'b1;
            addr     <= base_sel + AW'(cnt_sel);
            wdata    <= head_sel;
            cnt[sel] <= cnt_sel + CW'(1);
          end else begin
            state <= ST_PICK;
          end
        end
      endcase
    end
  end

  // R5: a selected port with pending work stays selected
  a_r5_hold_port: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DRAIN && elig[sel] && !clr) |=> (state == ST_DRAIN && sel == $past(sel)));

  // R7: finish lasts a single cycle
  a_r7_finish_pulse: assert property (@(posedge clk) disable iff (rst)
    finish |=> !finish);

  // R7: no write is in flight while finish is raised
  a_r7_finish_quiet: assert property (@(posedge clk) disable iff (rst)
    finish |-> !we);

  // R8: a clear cancels any write in the following cycle
  a_r8_clear_quiet: assert property (@(posedge clk) disable iff (rst)
    clr |=> !we);

  // R10: at most one FIFO is popped per cycle
  a_r10_single_pop: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pop));

endmodule

// File: rtl/result_storer.sv
// Multi-port result drain: per-port FIFOs into one memory write port.
module result_storer #(
  parameter int NPORTS     = 4,
  parameter int DW         = 32,
  parameter int AW         = 10,
  parameter int CW         = 10,
  parameter int FIFO_DEPTH = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic [NPORTS*AW-1:0] cfg_base,
  input  logic [NPORTS*CW-1:0] cfg_total,
  input  logic [NPORTS*DW-1:0] res_data,
  input  logic [NPORTS-1:0]    res_valid,
  output logic [NPORTS-1:0]    res_ready,
  output logic [NPORTS-1:0]    res_ack,
  output logic                 mem_we,
  output logic [AW-1:0]        mem_addr,
  output logic [DW-1:0]        mem_wdata,
  output logic                 finish
);
  logic [NPORTS-1:0]    pop, nonempty;
  logic [NPORTS*DW-1:0] heads;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    storer_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk          (clk),
      .rst          (rst),
      .in_data      (res_data[p*DW +: DW]),
      .in_valid     (res_valid[p]),
      .in_ready     (res_ready[p]),
      .in_ack       (res_ack[p]),
      .out_pop      (pop[p]),
      .out_head     (heads[p*DW +: DW]),
      .out_nonempty (nonempty[p])
    );

    // R2: an acknowledge always follows an accepted token
    a_r2_ack_after_accept: assert property (@(posedge clk) disable iff (rst)
      (res_valid[p] && res_ready[p]) |=> res_ack[p]);
  end

  storer_ctrl #(.NP(NPORTS), .DW(DW), .AW(AW), .CW(CW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .nonempty (nonempty),
    .head     (heads),
    .base     (cfg_base),
    .total    (cfg_total),
    .pop      (pop),
    .we       (mem_we),
    .addr     (mem_addr),
    .wdata    (mem_wdata),
    .finish   (finish)
  );

endmodule

// File: tb/tb_result_storer.sv
module tb_result_storer;
  localparam int NP = 3;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int CW = 6;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr = 1'b0;
  logic [NP*AW-1:0] cfg_base;
  logic [NP*CW-1:0] cfg_total;
  logic [NP*DW-1:0] res_data;
  logic [NP-1:0] res_valid, res_ready, res_ack;
  logic mem_we, finish;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  logic vld [NP];
  logic [DW-1:0] dat [NP];
  int tot [NP];
  int bas [NP];

  assign res_valid = {vld[2], vld[1], vld[0]};
  assign res_data  = {dat[2], dat[1], dat[0]};
  assign cfg_total = {CW'(tot[2]), CW'(tot[1]), CW'(tot[0])};
  assign cfg_base  = {AW'(bas[2]), AW'(bas[1]), AW'(bas[0])};

  result_storer #(.NPORTS(NP), .DW(DW), .AW(AW), .CW(CW), .FIFO_DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .clr(clr), .cfg_base(cfg_base), .cfg_total(cfg_total),
    .res_data(res_data), .res_valid(res_valid), .res_ready(res_ready),
    .res_ack(res_ack), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .finish(finish)
  );

  // 10-unit period: 100 MHz at 1 ns units
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cur_round = 0;
  bit big_test = 1'b0;

  int cyc = 0;
  int wr_cnt [NP];
  int ack_cnt [NP];
  int last_cyc [NP];
  int fin_cnt = 0;
  int wr_total = 0;
  int last_p = -1;
  int switches = 0;
  int seq [8];
  bit saw_full2 = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (round %0d)", req, act, exp, cur_round);
    end
  endtask

  // output monitor, sampled 2 units after each rising edge
  always begin
    @(posedge clk);
    #2;
    cyc++;
    if (rst || clr) begin
      for (int p = 0; p < NP; p++) begin
        wr_cnt[p] = 0; ack_cnt[p] = 0; last_cyc[p] = 0;
      end
      fin_cnt = 0; wr_total = 0; last_p = -1; switches = 0; saw_full2 = 1'b0;
    end else begin
      if (!res_ready[2]) saw_full2 = 1'b1;
      for (int p = 0; p < NP; p++) if (res_ack[p]) ack_cnt[p]++;
      if (mem_we) begin
        automatic int p = int'(mem_wdata[7:4]);
        automatic int k = int'(mem_wdata[3:0]);
        chk(p < NP, "R4 port field", p, 0);
        if (p < NP) begin
          chk(int'(mem_wdata[15:8]) == (cur_round & 255), "R4 round tag",
              int'(mem_wdata[15:8]), cur_round & 255);
          chk(k == wr_cnt[p], "R4 order", k, wr_cnt[p]);
          chk(int'(mem_addr) == bas[p] + wr_cnt[p], "R4 address",
              int'(mem_addr), bas[p] + wr_cnt[p]);
          chk(wr_cnt[p] < tot[p], "R9 no write past total", wr_cnt[p], tot[p] - 1);
          if (big_test && p == 0 && k > 0)
            chk(cyc - last_cyc[0] == 1, "R10 back-to-back", cyc - last_cyc[0], 1);
          if (last_p != p) begin
            if (last_p >= 0) switches++;
            if (switches < 8) seq[switches] = p;
          end
          last_p = p;
          last_cyc[p] = cyc;
          wr_cnt[p]++;
        end
        wr_total++;
      end
      if (finish) begin
        fin_cnt++;
        chk(wr_total == tot[0] + tot[1] + tot[2], "R7 all stored at finish",
            wr_total, tot[0] + tot[1] + tot[2]);
      end
    end
  end

  task automatic push(input int p, input int n, input int rnd);
    for (int k = 0; k < n; k++) begin
      automatic bit acc = 1'b0;
      vld[p] = 1'b1;
      dat[p] = {rnd[7:0], p[3:0], k[3:0]};
      while (!acc) begin
        acc = res_ready[p];
        @(negedge clk);
      end
    end
    vld[p] = 1'b0;
  endtask

  task automatic wait_finish();
    for (int i = 0; i < 300 && fin_cnt == 0; i++) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic end_checks(input int extra0);
    chk(fin_cnt == 1, "R7 single finish", fin_cnt, 1);
    for (int p = 0; p < NP; p++) begin
      chk(wr_cnt[p] == tot[p], "R3 all tokens stored", wr_cnt[p], tot[p]);
      chk(ack_cnt[p] == tot[p] + (p == 0 ? extra0 : 0), "R2 ack count",
          ack_cnt[p], tot[p] + (p == 0 ? extra0 : 0));
    end
  endtask

  initial begin
    for (int p = 0; p < NP; p++) begin
      vld[p] = 1'b0; dat[p] = '0; tot[p] = 10; bas[p] = p * 40;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(res_ready == 3'b111, "R1 ready after reset", int'(res_ready), 7);
    chk(!mem_we && !finish && res_ack == 3'b000, "R1 idle outputs",
        int'({mem_we, finish, res_ack}), 0);

    // long concurrent stream on all ports
    big_test = 1'b1;
    cur_round = 200;
    fork
      push(0, 10, 200);
      push(1, 10, 200);
      push(2, 10, 200);
    join
    wait_finish();
    end_checks(0);
    chk(switches == 2, "R5 one block per port", switches, 2);
    chk(seq[0] == 0 && seq[1] == 1 && seq[2] == 2, "R6 rotation order",
        seq[0] * 100 + seq[1] * 10 + seq[2], 12);
    chk(saw_full2, "R3 ready low when full", int'(saw_full2), 1);
    big_test = 1'b0;

    // sweep of every total combination 0..3 per port
    for (int r = 0; r < 64; r++) begin
      cur_round = r;
      tot[0] = r % 4; tot[1] = (r / 4) % 4; tot[2] = r / 16;
      for (int p = 0; p < NP; p++) bas[p] = p * 40 + (r % 8);
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      fork
        push(0, tot[0], r);
        push(1, tot[1], r);
        push(2, tot[2], r);
      join
      wait_finish();
      end_checks(0);
      if (r == 0) chk(fin_cnt == 1, "R8 zero totals finish after clear", fin_cnt, 1);
    end

    // more tokens than the total on port 0
    cur_round = 201;
    tot[0] = 2; tot[1] = 0; tot[2] = 0;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    push(0, 3, 201);
    wait_finish();
    repeat (20) @(negedge clk);
    end_checks(1);
    chk(res_ready[0] == 1'b1, "R9 extra token held, ready high", int'(res_ready[0]), 1);

    rst = 1'b1;
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule